// File: doc/BRIEF.md
# Mode-Configurable GPIO Port

This block is an eight-pin general-purpose I/O port. It holds a latch of output values and a mode for each pin. Each pin can be in one of four modes: handed to an alternate on-chip function, driven as a general output, or read as an input with or without the pad pull-up. A small synchronous register bus writes and reads the output latch and the mode word. The block decodes the modes into pad control lines for each pin: the output value, the output enable, the pull-up enable and the alternate-function select. Pin levels pass through a synchronizer before they can be read back.

A read of the data location returns a value built pin by pin. A pin in alternate or output mode returns its latch bit. A pin in either input mode returns the synchronized pad level. A write always lands in the latch, whatever the mode. The written value reaches the pad only while that pin is in output mode, so software can preload a value before it turns a pin into an output.

Two resets are supported. Power-on reset clears everything. Manual reset returns every pin to alternate mode but keeps the latch contents. While the retention input is high, the registers are frozen against bus writes.

Top module: `gpio_port`

## Requirements
- R1: The output latch is 8 bits at bus address 0, and latch bit n belongs to pin n. A data read places the per-pin result on rdata_o[7:0], with rdata_o[15:8] at zero.
- R2: The mode word is at bus address 1. Pin n's mode sits at bits [2n+1:2n], coded 00 alternate, 01 output, 10 input with pull-up, 11 input without pull-up. The word reads back exactly as written.
- R3: For a pin in mode 00 or 01, a data read returns that pin's latch bit, whatever the pin level.
- R4: For a pin in mode 10 or 11, a data read returns the pin level after a two-flop synchronizer. A read strobed at clock edge k returns the level that was present at edge k-2.
- R5: A write to address 0 updates all eight latch bits in every mode. pad_do_o[n] carries latch bit n only in mode 01 and is 0 in every other mode.
- R6: pad_oe_o[n] is 1 only in mode 01. pad_pu_o[n] is 1 only in mode 10. pad_alt_o[n] is 1 only in mode 00.
- R7: Power-on reset (por_n low) clears the latch to 0x00 and the mode word to 0x0000, so every pin is in alternate mode. It also clears the read outputs.
- R8: Manual reset (mrst_n low) clears the mode word and the read outputs. It leaves the latch unchanged, and bus writes are not taken while it is low.
- R9: While retain_i is high, writes to both registers are ignored and their contents hold. Reads still work.
- R10: Read data is registered. rvalid_o is high in the cycle after rd_en_i, and rdata_o holds its value until the next read. A read and a write to the same address in one cycle return the value held before the write.
- R11: Addresses 2 and 3 are unmapped. Reads from them return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| mrst_n | input | 1 | Manual reset, asynchronous, active low |
| retain_i | input | 1 | Low-power retention indication; blocks register writes |
| addr_i | input | 2 | Register bus address |
| wr_en_i | input | 1 | Register bus write strobe |
| rd_en_i | input | 1 | Register bus read strobe |
| wdata_i | input | 16 | Register bus write data |
| rdata_o | output | 16 | Registered read data |
| rvalid_o | output | 1 | Read data valid, one cycle after rd_en_i |
| pin_i | input | 8 | Pad input levels, asynchronous |
| pad_do_o | output | 8 | Pad output value per pin |
| pad_oe_o | output | 8 | Pad output enable per pin |
| pad_pu_o | output | 8 | Pad pull-up enable per pin |
| pad_alt_o | output | 8 | Alternate-function select per pin |

## Verification
The hardest case to reach is a data read in which pins in different modes return different sources in the same word, while the pad inputs move. The latch then holds a value different from the pad levels, so a wrong source for any one bit shows up. The stimulus first loads a mode word that mixes all four codes across the pins. It then writes a latch pattern and drives pad patterns that are the complement of it. It issues reads on the cycle right after a pad change, one cycle later and two cycles later, so that the synchronizer latency is pinned down exactly. A further phase issues random bus traffic, pad changes, retention windows and manual resets, and a behavioural model checks every output on every clock.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   typedef enum logic [1:0] {
      PM_ALT      = 2'b00,
      PM_OUT      = 2'b01,
      PM_IN_PULL  = 2'b10,
      PM_IN_FLOAT = 2'b11
   } pin_mode_e;

   localparam int unsigned MODE_W    = 2;
   localparam int unsigned LOC_LATCH = 0;
   localparam int unsigned LOC_MODE  = 1;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_port_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= async_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[s] <= '0;
            else        chain_q[s] <= chain_q[s-1];
         end
      end
   end

   assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_port_pin.sv
module gpio_port_pin
   import gpio_port_pkg::*;
(
   input  logic [MODE_W-1:0] mode_i,
   input  logic              latch_i,
   input  logic              level_i,
   output logic              pad_do_o,
   output logic              pad_oe_o,
   output logic              pad_pu_o,
   output logic              pad_alt_o,
   output logic              rd_bit_o
);

   pin_mode_e mode;

   always_comb begin
      mode      = pin_mode_e'(mode_i);
      pad_do_o  = 1'b0;
      pad_oe_o  = 1'b0;
      pad_pu_o  = 1'b0;
      pad_alt_o = 1'b0;
      rd_bit_o  = latch_i;
      unique case (mode)
         PM_ALT: begin
            pad_alt_o = 1'b1;
         end
         PM_OUT: begin
            pad_oe_o = 1'b1;
            pad_do_o = latch_i;
         end
         PM_IN_PULL: begin
            pad_pu_o = 1'b1;
            rd_bit_o = level_i;
         end
         PM_IN_FLOAT: begin
            rd_bit_o = level_i;
         end
         default: begin
            rd_bit_o = latch_i;
         end
      endcase
   end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned DATA_W = 16,
   localparam int unsigned MODE_BITS = 2 * NPINS
) (
   input  logic                 clk,
   input  logic                 por_n,
   input  logic                 mrst_n,
   input  logic                 retain_i,
   input  logic                 wr_latch_i,
   input  logic                 wr_mode_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [NPINS-1:0]     latch_o,
   output logic [MODE_BITS-1:0] mode_o
);

   logic [NPINS-1:0]     latch_q;
   logic [MODE_BITS-1:0] mode_q;
   logic                 wr_allowed;

   assign wr_allowed = mrst_n && !retain_i;

   // latch: only power-on reset clears it
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         latch_q <= '0;
      end else if (wr_latch_i && wr_allowed) begin
         latch_q <= wdata_i[NPINS-1:0];
      end
   end

   // mode word: either reset clears it
   always_ff @(posedge clk or negedge por_n or negedge mrst_n) begin
      if (!por_n || !mrst_n) begin
         mode_q <= '0;
      end else if (wr_mode_i && !retain_i) begin
         mode_q <= wdata_i[MODE_BITS-1:0];
      end
   end

   assign latch_o = latch_q;
   assign mode_o  = mode_q;

endmodule

// File: rtl/gpio_port.sv
module gpio_port
   import gpio_port_pkg::*;
#(
   parameter int unsigned NPINS       = 8,
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              mrst_n,
   input  logic              retain_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              wr_en_i,
   input  logic              rd_en_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rvalid_o,
   input  logic [NPINS-1:0]  pin_i,
   output logic [NPINS-1:0]  pad_do_o,
   output logic [NPINS-1:0]  pad_oe_o,
   output logic [NPINS-1:0]  pad_pu_o,
   output logic [NPINS-1:0]  pad_alt_o
);

   localparam int unsigned MODE_BITS = MODE_W * NPINS;

   if (MODE_BITS > DATA_W) begin : g_bad_width
      $error("gpio_port: DATA_W too narrow for the mode word");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("gpio_port: ADDR_W must be at least 1");
   end

   logic [NPINS-1:0]     latch_q;
   logic [MODE_BITS-1:0] mode_q;
   logic [NPINS-1:0]     level_s;
   logic [NPINS-1:0]     rd_bits;
   logic                 hit_latch;
   logic                 hit_mode;
   logic [DATA_W-1:0]    latch_word;
   logic [DATA_W-1:0]    mode_word;
   logic [DATA_W-1:0]    rd_word;
   logic [DATA_W-1:0]    rdata_q;
   logic                 rvalid_q;

   assign hit_latch = (addr_i == ADDR_W'(LOC_LATCH));
   assign hit_mode  = (addr_i == ADDR_W'(LOC_MODE));

   gpio_port_regs #(
      .NPINS  (NPINS),
      .DATA_W (DATA_W)
   ) u_regs (
      .clk        (clk),
      .por_n      (por_n),
      .mrst_n     (mrst_n),
      .retain_i   (retain_i),
      .wr_latch_i (wr_en_i && hit_latch),
      .wr_mode_i  (wr_en_i && hit_mode),
      .wdata_i    (wdata_i),
      .latch_o    (latch_q),
      .mode_o     (mode_q)
   );

   gpio_port_sync #(
      .WIDTH  (NPINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk     (clk),
      .rst_n   (por_n),
      .async_i (pin_i),
      .sync_o  (level_s)
   );

   for (genvar n = 0; n < NPINS; n++) begin : g_pin
      gpio_port_pin u_pin (
         .mode_i    (mode_q[MODE_W*n +: MODE_W]),
         .latch_i   (latch_q[n]),
         .level_i   (level_s[n]),
         .pad_do_o  (pad_do_o[n]),
         .pad_oe_o  (pad_oe_o[n]),
         .pad_pu_o  (pad_pu_o[n]),
         .pad_alt_o (pad_alt_o[n]),
         .rd_bit_o  (rd_bits[n])
      );
   end

   // zero-extend readback words when the bus is wider than the field
   if (DATA_W > NPINS) begin : g_ext_latch
      assign latch_word = {{(DATA_W-NPINS){1'b0}}, rd_bits};
   end else begin : g_full_latch
      assign latch_word = rd_bits;
   end

   if (DATA_W > MODE_BITS) begin : g_ext_mode
      assign mode_word = {{(DATA_W-MODE_BITS){1'b0}}, mode_q};
   end else begin : g_full_mode
      assign mode_word = mode_q;
   end

   always_comb begin
      if (hit_latch)     rd_word = latch_word;
      else if (hit_mode) rd_word = mode_word;
      else               rd_word = '0;
   end

   always_ff @(posedge clk or negedge por_n or negedge mrst_n) begin
      if (!por_n || !mrst_n) begin
         rdata_q  <= '0;
         rvalid_q <= 1'b0;
      end else begin
         rvalid_q <= rd_en_i;
         if (rd_en_i) rdata_q <= rd_word;
      end
   end

   assign rdata_o  = rdata_q;
   assign rvalid_o = rvalid_q;

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int unsigned NPINS  = 8,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 2
) (
   input logic                 clk,
   input logic                 por_n,
   input logic                 mrst_n,
   input logic                 retain_i,
   input logic [ADDR_W-1:0]    addr_i,
   input logic                 rd_en_i,
   input logic [DATA_W-1:0]    rdata_o,
   input logic                 rvalid_o,
   input logic [NPINS-1:0]     pad_do_o,
   input logic [NPINS-1:0]     pad_oe_o,
   input logic [NPINS-1:0]     pad_pu_o,
   input logic [NPINS-1:0]     pad_alt_o,
   input logic [NPINS-1:0]     latch_q,
   input logic [2*NPINS-1:0]   mode_q
);

   p_pad_excl_r6: assert property (@(posedge clk) disable iff (!por_n)
      ((pad_oe_o & pad_pu_o) | (pad_oe_o & pad_alt_o) | (pad_pu_o & pad_alt_o)) == '0);

   p_do_gated_r5: assert property (@(posedge clk) disable iff (!por_n)
      (pad_do_o & ~pad_oe_o) == '0);

   for (genvar n = 0; n < NPINS; n++) begin : g_pin_chk
      p_oe_mode_r6: assert property (@(posedge clk) disable iff (!por_n)
         pad_oe_o[n] == (mode_q[2*n+1:2*n] == 2'b01));
      p_alt_mode_r6: assert property (@(posedge clk) disable iff (!por_n)
         pad_alt_o[n] == (mode_q[2*n+1:2*n] == 2'b00));
   end

   p_rvalid_r10: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
      rd_en_i |=> rvalid_o);

   p_rvalid_idle_r10: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
      !rd_en_i |=> !rvalid_o);

   p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
      (rd_en_i && addr_i > ADDR_W'(1)) |=> rdata_o == '0);

   p_retain_hold_r9: assert property (@(posedge clk) disable iff (!por_n || !mrst_n)
      retain_i |=> ($stable(latch_q) && $stable(mode_q)));

   p_mrst_keep_r8: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |=> $stable(latch_q));

   p_mrst_mode_r8: assert property (@(posedge clk) disable iff (!por_n)
      !mrst_n |-> (mode_q == '0 && pad_alt_o == '1));

   always @(posedge clk) begin
      if (!por_n) begin
         p_por_clear_r7: assert (latch_q == '0 && mode_q == '0 && rvalid_o == 1'b0);
      end
   end

endmodule

bind gpio_port gpio_port_chk #(
   .NPINS  (NPINS),
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .por_n     (por_n),
   .mrst_n    (mrst_n),
   .retain_i  (retain_i),
   .addr_i    (addr_i),
   .rd_en_i   (rd_en_i),
   .rdata_o   (rdata_o),
   .rvalid_o  (rvalid_o),
   .pad_do_o  (pad_do_o),
   .pad_oe_o  (pad_oe_o),
   .pad_pu_o  (pad_pu_o),
   .pad_alt_o (pad_alt_o),
   .latch_q   (latch_q),
   .mode_q    (mode_q)
);

// File: tb/tb_gpio_port.sv
module tb_gpio_port;

   localparam int NP = 8;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        mrst_n = 1'b1;
   logic        retain_i = 1'b0;
   logic [1:0]  addr_i = '0;
   logic        wr_en_i = 1'b0;
   logic        rd_en_i = 1'b0;
   logic [15:0] wdata_i = '0;
   logic [15:0] rdata_o;
   logic        rvalid_o;
   logic [7:0]  pin_i = '0;
   logic [7:0]  pad_do_o, pad_oe_o, pad_pu_o, pad_alt_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   gpio_port dut (
      .clk(clk), .por_n(por_n), .mrst_n(mrst_n), .retain_i(retain_i),
      .addr_i(addr_i), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .wdata_i(wdata_i),
      .rdata_o(rdata_o), .rvalid_o(rvalid_o), .pin_i(pin_i),
      .pad_do_o(pad_do_o), .pad_oe_o(pad_oe_o), .pad_pu_o(pad_pu_o),
      .pad_alt_o(pad_alt_o)
   );

   // ---------------- behavioural reference model ----------------
   int    m_latch = 0;
   int    m_mode [NP];
   int    m_s1 = 0, m_s2 = 0;
   int    m_rd = 0;
   int    m_rv = 0;
   string m_tag = "R7";

   initial foreach (m_mode[i]) m_mode[i] = 0;

   function automatic int model_read(int a);
      int v = 0;
      if (a == 0) begin
         for (int n = 0; n < NP; n++) begin
            if (m_mode[n] >= 2) v |= ((m_s2 >> n) & 1) << n;
            else                v |= ((m_latch >> n) & 1) << n;
         end
      end else if (a == 1) begin
         for (int n = 0; n < NP; n++) v |= m_mode[n] << (2*n);
      end
      return v;
   endfunction

   always @(posedge clk) begin
      if (!por_n) begin
         m_latch = 0; m_s1 = 0; m_s2 = 0; m_rd = 0; m_rv = 0; m_tag = "R7";
         foreach (m_mode[i]) m_mode[i] = 0;
      end else begin
         if (!mrst_n) begin
            foreach (m_mode[i]) m_mode[i] = 0;
            m_rd = 0; m_rv = 0; m_tag = "R8";
         end else begin
            if (rd_en_i) begin
               m_rd  = model_read(int'(addr_i));
               m_tag = (addr_i == 0) ? "R1 R3 R4" : (addr_i == 1) ? "R2" : "R11";
            end
            m_rv = rd_en_i ? 1 : 0;
            if (wr_en_i && !retain_i) begin
               if (addr_i == 0) m_latch = int'(wdata_i[7:0]);
               if (addr_i == 1) for (int n = 0; n < NP; n++) m_mode[n] = int'(wdata_i[2*n +: 2]);
            end
         end
         m_s2 = m_s1;
         m_s1 = int'(pin_i);
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (!done) begin
         logic [7:0] e_do, e_oe, e_pu, e_alt;
         e_do = '0; e_oe = '0; e_pu = '0; e_alt = '0;
         for (int n = 0; n < NP; n++) begin
            e_oe[n]  = (m_mode[n] == 1);
            e_do[n]  = (m_mode[n] == 1) && (((m_latch >> n) & 1) == 1);
            e_pu[n]  = (m_mode[n] == 2);
            e_alt[n] = (m_mode[n] == 0);
         end
         chk(m_tag, 32'(rdata_o), 32'(m_rd));
         chk("R10", 32'(rvalid_o), 32'(m_rv));
         chk("R5", 32'(pad_do_o), 32'(e_do));
         chk("R6 oe", 32'(pad_oe_o), 32'(e_oe));
         chk("R6 pu", 32'(pad_pu_o), 32'(e_pu));
         chk("R6 alt", 32'(pad_alt_o), 32'(e_alt));
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic bus_wr(logic [1:0] a, logic [15:0] d);
      step(); addr_i = a; wdata_i = d; wr_en_i = 1'b1;
      step(); wr_en_i = 1'b0;
   endtask

   task automatic bus_rd_expect(logic [1:0] a, logic [15:0] exp, string tag);
      step(); addr_i = a; rd_en_i = 1'b1;
      step(); rd_en_i = 1'b0;
      chk(tag, 32'(rdata_o), 32'(exp));
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 8);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      finish_run();
   end

   initial begin
      // R7: reset state
      repeat (3) step();
      chk("R7 pads", 32'({pad_oe_o, pad_alt_o}), 32'h00FF);
      por_n = 1'b1;
      bus_rd_expect(2'd0, 16'h0000, "R7 latch");
      bus_rd_expect(2'd1, 16'h0000, "R7 mode");

      // R3 R5: write in alternate mode reaches latch, not the pad
      pin_i = 8'h5A;
      bus_wr(2'd0, 16'hFFA5);
      chk("R5 no drive", 32'(pad_do_o), 32'h0);
      bus_rd_expect(2'd0, 16'h00A5, "R1 R3");

      // R2: mixed mode word, all four codes present
      bus_wr(2'd1, 16'h7939);
      bus_rd_expect(2'd1, 16'h7939, "R2");
      chk("R6 oe mixed", 32'(pad_oe_o), 32'h91);
      chk("R6 pu mixed", 32'(pad_pu_o), 32'h22);

      // R4: input pins return synchronized level with two-edge latency
      pin_i = 8'hFF;
      step(); addr_i = 2'd0; rd_en_i = 1'b1;   // read right after the change
      step(); step(); rd_en_i = 1'b0;
      pin_i = 8'h00;
      repeat (3) step();
      bus_rd_expect(2'd0, 16'h0081, "R3 R4 mixed");   // pins 1,2,5,6 low, others latch A5

      // R10: simultaneous read and write on same address
      step(); addr_i = 2'd0; rd_en_i = 1'b1; wr_en_i = 1'b1; wdata_i = 16'h003C;
      step(); rd_en_i = 1'b0; wr_en_i = 1'b0;
      chk("R10 old value", 32'(rdata_o), 32'h0081);
      bus_wr(2'd1, 16'h5555);
      bus_rd_expect(2'd0, 16'h003C, "R10 new value");
      chk("R5 drive", 32'(pad_do_o), 32'h3C);

      // R11: unmapped addresses
      bus_wr(2'd2, 16'hFFFF);
      bus_wr(2'd3, 16'hFFFF);
      bus_rd_expect(2'd2, 16'h0000, "R11 read2");
      bus_rd_expect(2'd3, 16'h0000, "R11 read3");
      bus_rd_expect(2'd1, 16'h5555, "R11 mode untouched");

      // R9: retention blocks writes
      step(); retain_i = 1'b1;
      bus_wr(2'd0, 16'h00C3);
      bus_wr(2'd1, 16'hFFFF);
      bus_rd_expect(2'd0, 16'h003C, "R9 latch held");
      bus_rd_expect(2'd1, 16'h5555, "R9 mode held");
      step(); retain_i = 1'b0;

      // R8: manual reset keeps latch, clears modes
      step(); mrst_n = 1'b0; addr_i = 2'd0; wdata_i = 16'h00FF; wr_en_i = 1'b1;
      step(); step(); wr_en_i = 1'b0;
      chk("R8 pads alt", 32'(pad_alt_o), 32'hFF);
      mrst_n = 1'b1;
      bus_rd_expect(2'd1, 16'h0000, "R8 mode cleared");
      bus_rd_expect(2'd0, 16'h003C, "R8 latch kept");

      // random traffic phase
      for (int i = 0; i < 600; i++) begin
         step();
         addr_i   = 2'($urandom_range(0, 3));
         wdata_i  = 16'($urandom);
         wr_en_i  = ($urandom_range(0, 2) == 0);
         rd_en_i  = ($urandom_range(0, 1) == 0);
         pin_i    = ($urandom_range(0, 3) == 0) ? 8'($urandom) : pin_i;
         retain_i = ($urandom_range(0, 9) == 0);
         mrst_n   = ($urandom_range(0, 40) != 0);
      end
      step(); wr_en_i = 1'b0; rd_en_i = 1'b0; retain_i = 1'b0; mrst_n = 1'b1;

      // R7: power-on reset mid-run clears latch
      bus_wr(2'd0, 16'h00EE);
      step(); por_n = 1'b0;
      step(); por_n = 1'b1;
      bus_rd_expect(2'd0, 16'h0000, "R7 latch cleared");
      repeat (2) step();
      finish_run();
   end

endmodule